// File: doc/BRIEF.md
# Ordered Store Buffer with Store-to-Load Fence

This block sits between a core's load/store port and a single memory port. Stores enter an ordered queue and leave for memory one at a time, oldest first. Each entry stays in the queue until memory acknowledges its write. A load searches the queue by address. If it finds a match, it is answered from the queue with the data of the youngest matching store. If it finds none, the load is sent to memory and may overtake older stores that are still waiting to drain.

A fence input accepts four kinds. The store-to-load kind holds back every later load until the queue is empty. The other three kinds complete at once. A store may also enter before its address is known. While any such entry is present, the held load cannot be decided and the queue head cannot drain. A separate input later supplies the address, and it is applied to the oldest unresolved entry.

The memory port runs a state machine with five states:
- `M_IDLE`: no request outstanding.
- `M_RD_REQ` and `M_WR_REQ`: a request is presented and held until memory is ready.
- `M_RD_WAIT` and `M_WR_WAIT`: waiting for the response.

Its transitions:
- `M_IDLE` to `M_RD_REQ` when a load must go to memory. This takes priority over draining.
- Otherwise, `M_IDLE` to `M_WR_REQ` when the head entry has a known address.
- Each request state to its wait state on the request handshake.
- Each wait state back to `M_IDLE` on the response.

Top module: `store_fence_buf`

## Requirements
- R1: After reset, st_ready, ld_ready and fence_ready are 1, and fence_busy, mem_req_valid and ld_rsp_valid are 0.
- R2: Writes leave in store arrival order, with the address and data of the oldest entry. At most one memory transaction is outstanding. An entry is freed only by the write response.
- R3: With DEPTH entries held, st_ready is 0, except in a cycle that carries a write response; a store offered in that cycle is accepted.
- R4: A load whose address matches no queued store is read from memory, even while older stores are still queued.
- R5: A load whose address matches queued stores is answered with the youngest matching store's data, and no memory read is issued.
- R6: A load to the address of a write that is already in flight is still answered from the queue.
- R7: An accepted fence with fence_kind = 3 (store-to-load) and a non-empty queue sets fence_busy. While fence_busy is 1, ld_ready is 0, whatever the load's address. fence_busy falls only after the queue is empty.
- R8: Fences with fence_kind 0, 1 or 2 are accepted in the cycle they are offered, never set fence_busy, and do not delay a following load.
- R9: While a queued store has no known address (st_addr_known = 0), no load is answered and that store does not drain. A pulse on addr_fix_valid gives the oldest such entry its address. When no such entry exists, the pulse is ignored.
- R10: A memory request is held, with unchanged address and type, until mem_req_ready is seen.
- R11: ld_rsp_valid is a one-cycle pulse, and ld_ready returns to 1 in the same cycle.
- R12: While a load is held or fence_busy is 1, st_ready, ld_ready and fence_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | AW | Store address |
| st_addr_known | input | 1 | Store address is valid |
| st_data | input | DW | Store data |
| addr_fix_valid | input | 1 | Supply the address of the oldest unresolved store |
| addr_fix_addr | input | AW | Supplied address |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load accepted this cycle |
| ld_addr | input | AW | Load address |
| ld_rsp_valid | output | 1 | Load data valid (one cycle) |
| ld_rsp_data | output | DW | Load data |
| fence_valid | input | 1 | Fence offered |
| fence_kind | input | 2 | 0 load-load, 1 store-store, 2 load-store, 3 store-load |
| fence_ready | output | 1 | Fence accepted this cycle |
| fence_busy | output | 1 | Store-to-load fence waiting for the queue to empty |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_rdata | input | DW | Read data |

## Verification
A wrong head pointer or count shows up as soon as the next write request is presented, because its address or data differs from the oldest store in a behavioural queue. It also shows up in the very cycle that st_ready disagrees with the modelled fill level. A wrong age priority in the address search shows up on the first load that hits more than one entry: the returned data differs from the program-order value of that address, or a read appears that should not exist. A fence flag that is set or cleared at the wrong time shows up within one cycle, on fence_busy and ld_ready, because the reference model predicts both on every clock.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        FK_LD_LD = 2'd0,
        FK_ST_ST = 2'd1,
        FK_LD_ST = 2'd2,
        FK_ST_LD = 2'd3
    } fence_kind_e;

    typedef enum logic [2:0] {
        M_IDLE,
        M_RD_REQ,
        M_RD_WAIT,
        M_WR_REQ,
        M_WR_WAIT
    } mem_state_e;

endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          push_known,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          fix,
    input  logic [AW-1:0] fix_addr,
    input  logic [AW-1:0] look_addr,
    output logic [CW-1:0] count,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          head_known,
    output logic          any_unknown,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] known_q;
    logic [PW-1:0]    head_q;
    logic [PW-1:0]    tail;
    logic [CW-1:0]    count_q;
    logic [PW-1:0]    fix_idx;
    logic             fix_any;

    assign tail       = head_q + PW'(count_q);
    assign count      = count_q;
    assign head_addr  = addr_q[head_q];
    assign head_data  = data_q[head_q];
    assign head_known = known_q[head_q] && (count_q != '0);

    // Age-ordered search: a later (younger) match overrides an older one.
    always_comb begin
        hit         = 1'b0;
        hit_data    = '0;
        any_unknown = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < count_q) begin
                if (!known_q[head_q + PW'(i)]) begin
                    any_unknown = 1'b1;
                end else if (addr_q[head_q + PW'(i)] == look_addr) begin
                    hit      = 1'b1;
                    hit_data = data_q[head_q + PW'(i)];
                end
            end
        end
    end

    // The oldest unresolved entry receives a supplied address.
    always_comb begin
        fix_any = 1'b0;
        fix_idx = head_q;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if ((CW'(i) < count_q) && !known_q[head_q + PW'(i)]) begin
                fix_any = 1'b1;
                fix_idx = head_q + PW'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
            known_q <= '0;
        end else begin
            if (fix && fix_any) known_q[fix_idx] <= 1'b1;
            if (push)           known_q[tail]    <= push_known;
            if (pop)            head_q           <= head_q + PW'(1);
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (fix && fix_any) addr_q[fix_idx] <= fix_addr;
        if (push) begin
            addr_q[tail] <= push_addr;
            data_q[tail] <= push_data;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q < CW'(DEPTH)) || pop);
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count_q != '0);
    p_pop_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> known_q[head_q]);

endmodule

// File: rtl/sbuf_mem_fsm.sv
module sbuf_mem_fsm
    import sbuf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_want,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_want,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    output logic          rd_take,
    output logic          rd_done,
    output logic          wr_done
);

    mem_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE: begin
                if (rd_want)      state_d = M_RD_REQ;
                else if (wr_want) state_d = M_WR_REQ;
            end
            M_RD_REQ:  if (mem_req_ready) state_d = M_RD_WAIT;
            M_RD_WAIT: if (mem_rsp_valid) state_d = M_IDLE;
            M_WR_REQ:  if (mem_req_ready) state_d = M_WR_WAIT;
            M_WR_WAIT: if (mem_rsp_valid) state_d = M_IDLE;
            default:   state_d = M_IDLE;
        endcase
    end

    always_comb begin
        mem_req_valid = (state_q == M_RD_REQ) || (state_q == M_WR_REQ);
        mem_req_write = (state_q == M_WR_REQ);
        mem_req_addr  = (state_q == M_RD_REQ) ? rd_addr : wr_addr;
        mem_req_wdata = wr_data;
        rd_take       = (state_q == M_IDLE) && rd_want;
        rd_done       = (state_q == M_RD_WAIT) && mem_rsp_valid;
        wr_done       = (state_q == M_WR_WAIT) && mem_rsp_valid;
    end

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: rtl/store_fence_buf.sv
module store_fence_buf
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic          st_addr_known,
    input  logic [DW-1:0] st_data,
    input  logic          addr_fix_valid,
    input  logic [AW-1:0] addr_fix_addr,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    input  logic          fence_valid,
    input  logic [1:0]    fence_kind,
    output logic          fence_ready,
    output logic          fence_busy,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic          head_known, any_unknown, hit;
    logic [DW-1:0] hit_data;
    logic          ld_busy, ld_sent;
    logic [AW-1:0] ld_addr_q;
    logic          push, ld_decide, fwd_now, rd_want, wr_want;
    logic          rd_take, rd_done, wr_done;

    assign ld_ready    = !ld_busy && !fence_busy;
    assign fence_ready = !ld_busy && !fence_busy;
    assign st_ready    = !ld_busy && !fence_busy && ((count < CW'(DEPTH)) || wr_done);
    assign push        = st_valid && st_ready;
    assign ld_decide   = ld_busy && !ld_sent && !any_unknown;
    assign fwd_now     = ld_decide && hit;
    assign rd_want     = ld_decide && !hit;
    assign wr_want     = head_known;

    sbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_addr   (st_addr),
        .push_known  (st_addr_known),
        .push_data   (st_data),
        .pop         (wr_done),
        .fix         (addr_fix_valid),
        .fix_addr    (addr_fix_addr),
        .look_addr   (ld_addr_q),
        .count       (count),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .head_known  (head_known),
        .any_unknown (any_unknown),
        .hit         (hit),
        .hit_data    (hit_data)
    );

    sbuf_mem_fsm #(.AW(AW), .DW(DW)) u_mem (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_want       (rd_want),
        .rd_addr       (ld_addr_q),
        .wr_want       (wr_want),
        .wr_addr       (head_addr),
        .wr_data       (head_data),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rd_take       (rd_take),
        .rd_done       (rd_done),
        .wr_done       (wr_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_busy      <= 1'b0;
            ld_sent      <= 1'b0;
            ld_addr_q    <= '0;
            ld_rsp_valid <= 1'b0;
            ld_rsp_data  <= '0;
        end else begin
            ld_rsp_valid <= 1'b0;
            if (ld_valid && ld_ready) begin
                ld_busy   <= 1'b1;
                ld_sent   <= 1'b0;
                ld_addr_q <= ld_addr;
            end
            if (rd_take) ld_sent <= 1'b1;
            if (fwd_now) begin
                ld_rsp_valid <= 1'b1;
                ld_rsp_data  <= hit_data;
                ld_busy      <= 1'b0;
            end
            if (rd_done) begin
                ld_rsp_valid <= 1'b1;
                ld_rsp_data  <= mem_rsp_rdata;
                ld_busy      <= 1'b0;
                ld_sent      <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fence_busy <= 1'b0;
        end else if (fence_valid && fence_ready
                     && (fence_kind_e'(fence_kind) == FK_ST_LD) && (count != '0)) begin
            fence_busy <= 1'b1;
        end else if (fence_busy && (count == '0)) begin
            fence_busy <= 1'b0;
        end
    end

    p_fence_holds_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fence_busy |-> !ld_ready);
    p_fence_drop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fence_busy) |-> (count == '0));
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rsp_valid |=> !ld_rsp_valid);
    p_unknown_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_busy && any_unknown) |=> !ld_rsp_valid);
    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == CW'(DEPTH)) && !mem_rsp_valid) |-> !st_ready);
    p_serialize_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_busy |-> (!st_ready && !fence_ready));

endmodule

// File: tb/tb_store_fence_buf.sv
module tb_store_fence_buf;

    localparam int DEPTH = 8;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        bit          k;
    } ent_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        st_valid, st_addr_known, addr_fix_valid, ld_valid, fence_valid;
    logic [31:0] st_addr, st_data, addr_fix_addr, ld_addr;
    logic [1:0]  fence_kind;
    logic        mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        st_ready, ld_ready, ld_rsp_valid, fence_ready, fence_busy;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] ld_rsp_data, mem_req_addr, mem_req_wdata;

    store_fence_buf #(.DEPTH(DEPTH), .AW(32), .DW(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_addr_known(st_addr_known), .st_data(st_data),
        .addr_fix_valid(addr_fix_valid), .addr_fix_addr(addr_fix_addr),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .fence_valid(fence_valid), .fence_kind(fence_kind),
        .fence_ready(fence_ready), .fence_busy(fence_busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference state
    logic [31:0] mem_arr [logic [31:0]];
    ent_t        mq[$];
    bit          m_fence = 0, m_ld = 0;
    logic [31:0] m_ld_a = '0;
    int          bypass_reads = 0, n_reads = 0;
    // Memory responder
    bit          mbusy = 0, mwr = 0, hold_ready = 0;
    int          mcnt = 0, lat = 2;
    logic [31:0] ma = '0, md = '0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    bit          prev_wr = 0, prev_rsp = 0;
    // Handshake flags seen by the tasks
    bit          hs_st, hs_ld, hs_fc, got_rsp, st_with_ack, ld_hs_empty;
    logic [31:0] rsp_seen;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem_arr.exists(a) ? mem_arr[a] : 32'h0;
    endfunction

    function automatic logic [31:0] view(input logic [31:0] a);
        logic [31:0] v = mem_rd(a);
        foreach (mq[i]) if (mq[i].k && mq[i].a == a) v = mq[i].d;
        return v;
    endfunction

    function automatic bit has_unknown();
        foreach (mq[i]) if (!mq[i].k) return 1;
        return 0;
    endfunction

    function automatic bit has_match(input logic [31:0] a);
        foreach (mq[i]) if (mq[i].k && mq[i].a == a) return 1;
        return 0;
    endfunction

    task automatic tick();
        bit wr_ack, pend, exp_rdy, fclr, fset;
        @(negedge clk);
        mem_rsp_valid = mbusy && (mcnt == 0);
        mem_rsp_rdata = (mbusy && !mwr) ? mem_rd(ma) : 32'h0;
        mem_req_ready = !mbusy && !hold_ready;
        #2;
        wr_ack  = mem_rsp_valid && mwr;
        pend    = m_ld && !ld_rsp_valid;
        exp_rdy = !pend && !m_fence;
        chk(ld_ready == exp_rdy, m_fence ? "R7 ld_ready" : "R12 ld_ready", 32'(ld_ready), 32'(exp_rdy));
        chk(fence_ready == exp_rdy, "R12 fence_ready", 32'(fence_ready), 32'(exp_rdy));
        chk(st_ready == (exp_rdy && (mq.size() < DEPTH || wr_ack)), "R3 st_ready",
            32'(st_ready), 32'(exp_rdy && (mq.size() < DEPTH || wr_ack)));
        chk(fence_busy == m_fence, "R7 fence_busy", 32'(fence_busy), 32'(m_fence));
        if (prev_rsp) chk(!ld_rsp_valid, "R11 pulse", 32'(ld_rsp_valid), 0);
        if (prev_stall)
            chk(mem_req_valid && mem_req_addr == prev_addr && mem_req_write == prev_wr,
                "R10 hold", mem_req_addr, prev_addr);
        if (ld_rsp_valid) begin
            chk(m_ld, "R11 rsp without load", 0, 1);
            chk(!has_unknown(), "R9 answered past unknown", 1, 0);
            chk(ld_rsp_data == view(m_ld_a), "R5 load data", ld_rsp_data, view(m_ld_a));
        end
        if (mem_req_valid) begin
            chk(!mbusy, "R2 one outstanding", 32'(mbusy), 0);
            if (mem_req_write) begin
                chk(mq.size() > 0 && mq[0].k, "R2 write from empty/unknown", 32'(mq.size()), 1);
                if (mq.size() > 0)
                    chk(mem_req_addr == mq[0].a && mem_req_wdata == mq[0].d, "R2 write order",
                        mem_req_addr, mq[0].a);
            end else begin
                chk(m_ld && mem_req_addr == m_ld_a, "R4 read addr", mem_req_addr, m_ld_a);
                chk(!has_match(m_ld_a) && !has_unknown(), "R6 read despite queued match", 1, 0);
            end
        end
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        prev_wr    = mem_req_write;
        prev_rsp   = ld_rsp_valid;
        // Model updates for the coming edge
        fclr = m_fence && mq.size() == 0;
        fset = fence_valid && fence_ready && fence_kind == 2'd3 && mq.size() != 0;
        if (fence_valid && fence_ready) hs_fc = 1;
        m_fence = fset ? 1'b1 : (fclr ? 1'b0 : m_fence);
        if (ld_rsp_valid) begin m_ld = 0; got_rsp = 1; rsp_seen = ld_rsp_data; end
        if (ld_valid && ld_ready) begin
            m_ld = 1; m_ld_a = ld_addr; hs_ld = 1;
            ld_hs_empty = (mq.size() == 0) && !mbusy;
        end
        if (addr_fix_valid) begin
            foreach (mq[i]) if (!mq[i].k) begin mq[i].a = addr_fix_addr; mq[i].k = 1; break; end
        end
        if (wr_ack) begin mem_arr[ma] = md; void'(mq.pop_front()); end
        if (st_valid && st_ready) begin
            mq.push_back('{a: st_addr, d: st_data, k: st_addr_known});
            hs_st = 1; st_with_ack = wr_ack;
        end
        if (mem_rsp_valid) mbusy = 0;
        else if (mbusy) mcnt--;
        if (mem_req_valid && mem_req_ready) begin
            if (!mem_req_write) begin n_reads++; if (mq.size() > 0) bypass_reads++; end
            mbusy = 1; mcnt = lat; mwr = mem_req_write; ma = mem_req_addr; md = mem_req_wdata;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input bit k);
        st_valid = 1; st_addr = a; st_data = d; st_addr_known = k; hs_st = 0;
        do tick(); while (!hs_st);
        st_valid = 0;
    endtask

    task automatic do_load(input logic [31:0] a);
        ld_valid = 1; ld_addr = a; hs_ld = 0; got_rsp = 0;
        do tick(); while (!hs_ld);
        ld_valid = 0;
        while (!got_rsp) tick();
    endtask

    task automatic drain();
        hold_ready = 0;
        while (mq.size() != 0 || mbusy || m_fence) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r0;
        rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0; st_addr_known = 0;
        addr_fix_valid = 0; addr_fix_addr = '0; ld_valid = 0; ld_addr = '0;
        fence_valid = 0; fence_kind = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = '0;
        mem_arr[32'h500] = 32'h55AA55AA;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #2;
        // R1 reset state
        chk(st_ready && ld_ready && fence_ready, "R1 readies", {st_ready, ld_ready, fence_ready}, 3'b111);
        chk(!fence_busy && !mem_req_valid && !ld_rsp_valid, "R1 idle outputs",
            {fence_busy, mem_req_valid, ld_rsp_valid}, 0);
        @(posedge clk); #1;

        // R2/R4: slow write in flight, unrelated load overtakes queued stores
        lat = 5;
        do_store(32'h100, 32'hA1, 1);
        do_store(32'h104, 32'hA2, 1);
        do_store(32'h108, 32'hA3, 1);
        do_load(32'h500);
        chk(rsp_seen == 32'h55AA55AA, "R4 read data", rsp_seen, 32'h55AA55AA);
        chk(bypass_reads > 0, "R4 bypass", bypass_reads, 1);
        drain();
        chk(mem_rd(32'h108) == 32'hA3, "R2 drained", mem_rd(32'h108), 32'hA3);

        // R5: youngest of several matches, no read
        hold_ready = 1; lat = 1;
        do_store(32'h200, 32'h11, 1);
        do_store(32'h204, 32'h22, 1);
        do_store(32'h200, 32'h33, 1);
        r0 = n_reads;
        do_load(32'h200);
        chk(rsp_seen == 32'h33, "R5 youngest", rsp_seen, 32'h33);
        chk(n_reads == r0, "R5 no read", n_reads, r0);
        drain();

        // R6: write already in flight, load same address
        lat = 8;
        do_store(32'h300, 32'h77, 1);
        while (!mbusy) tick();
        r0 = n_reads;
        do_load(32'h300);
        chk(rsp_seen == 32'h77, "R6 in-flight forward", rsp_seen, 32'h77);
        chk(n_reads == r0, "R6 no read", n_reads, r0);
        drain();

        // R3: fill, then accept on the write-response cycle
        hold_ready = 1; lat = 2;
        for (int i = 0; i < DEPTH; i++) do_store(32'h400 + 32'(4 * i), 32'h40 + 32'(i), 1);
        st_valid = 1; st_addr = 32'h4F0; st_data = 32'hFF; st_addr_known = 1; hs_st = 0;
        repeat (3) tick();
        chk(!hs_st, "R3 full blocks", 32'(hs_st), 0);
        hold_ready = 0;
        while (!hs_st) tick();
        st_valid = 0;
        chk(st_with_ack, "R3 same-cycle accept", 32'(st_with_ack), 1);
        drain();

        // R7: store-load fence stalls an unrelated load until empty
        hold_ready = 1;
        do_store(32'h600, 32'h66, 1);
        fence_valid = 1; fence_kind = 2'd3; hs_fc = 0;
        tick();
        fence_valid = 0;
        chk(hs_fc, "R7 fence accepted", 32'(hs_fc), 1);
        tick();
        chk(fence_busy, "R7 fence busy", 32'(fence_busy), 1);
        ld_valid = 1; ld_addr = 32'h700; hs_ld = 0; got_rsp = 0;
        repeat (4) tick();
        chk(!hs_ld, "R7 load held", 32'(hs_ld), 0);
        hold_ready = 0;
        while (!hs_ld) tick();
        ld_valid = 0;
        chk(ld_hs_empty, "R7 load after drain", 32'(ld_hs_empty), 1);
        while (!got_rsp) tick();
        drain();

        // R8: other fence kinds are one-cycle no-ops
        hold_ready = 1;
        do_store(32'hA00, 32'h1234, 1);
        for (int k = 0; k < 3; k++) begin
            fence_valid = 1; fence_kind = 2'(k); hs_fc = 0;
            tick();
            fence_valid = 0;
            chk(hs_fc, "R8 one-cycle accept", 32'(hs_fc), 1);
            tick();
            chk(!fence_busy, "R8 no busy", 32'(fence_busy), 0);
        end
        ld_valid = 1; ld_addr = 32'hA00; hs_ld = 0; got_rsp = 0;
        tick();
        chk(hs_ld, "R8 load not delayed", 32'(hs_ld), 1);
        ld_valid = 0;
        while (!got_rsp) tick();
        chk(rsp_seen == 32'h1234, "R8 load data", rsp_seen, 32'h1234);
        drain();

        // R9: unknown address blocks loads and drain until supplied
        lat = 1;
        do_store(32'hDEAD, 32'h99, 0);
        do_store(32'h804, 32'h05, 1);
        ld_valid = 1; ld_addr = 32'h900; hs_ld = 0; got_rsp = 0;
        tick();
        ld_valid = 0;
        repeat (6) tick();
        chk(!got_rsp && mq.size() == 2, "R9 blocked", 32'(mq.size()), 2);
        addr_fix_valid = 1; addr_fix_addr = 32'h800;
        tick();
        addr_fix_valid = 0;
        while (!got_rsp) tick();
        drain();
        chk(mem_rd(32'h800) == 32'h99, "R9 fixed address", mem_rd(32'h800), 32'h99);
        addr_fix_valid = 1; addr_fix_addr = 32'hBAD0;
        tick();
        addr_fix_valid = 0;
        do_load(32'h800);
        chk(rsp_seen == 32'h99, "R9 stray fix ignored", rsp_seen, 32'h99);

        // R10: read held while memory not ready
        hold_ready = 1;
        ld_valid = 1; ld_addr = 32'h500; hs_ld = 0; got_rsp = 0;
        tick();
        ld_valid = 0;
        repeat (5) tick();
        hold_ready = 0;
        while (!got_rsp) tick();
        chk(rsp_seen == 32'h55AA55AA, "R10 held read", rsp_seen, 32'h55AA55AA);
        repeat (4) tick();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule